// File: doc/BRIEF.md
# Memory-resident interrupt file updater

This block completes a redirected message-signalled interrupt whose target is an interrupt file kept in ordinary memory. The 32-bit write data of the interrupt message is the interrupt identity. The file in memory is an array of 64-bit groups. Each group takes 16 bytes: a pending word at the group's base and an enable word 8 bytes above it. The block reads both words of the identity's group. It writes the pending word back with the identity's bit set, and it can then post a 32-bit notice to a notification address.

The request carries the file's base address and the second word of the translation entry. That word supplies the notification page and an 11-bit notice identifier. The block drives a single-outstanding memory master port. It accepts no new request until the last memory access of the current one has been acknowledged, so the read-modify-write of the pending word cannot interleave with another update.

Top module: `mrif_notify_unit`

## Requirements
- R1: After reset `busy` and `mem_valid` are low and `req_ready` is high.
- R2: For identity N, the first access is a 64-bit read of the pending word at file base + 16*(N>>6). The second access is a 64-bit read of the enable word at that address + 8.
- R3: The third access is a 64-bit write (`mem_write`=1, `mem_wide`=1) to the pending address. Its data is the pending word just read, ORed with the single bit N mod 64. Every bit already set is preserved.
- R4: The notice is written to the address whose bits 55:12 are entry word bits 53:10 and whose bits 11:0 are zero. This address is truncated to the address width.
- R5: The notice is a 32-bit write (`mem_wide`=0). `mem_wdata[10]` carries entry word bit 60, `mem_wdata[9:0]` carry entry word bits 9:0, and all other data bits are zero.
- R6: The notice is written only when enable bit N mod 64 is set and pending bit N mod 64 was clear in the value read. Otherwise the request ends after the pending write.
- R7: A request with identity 0 is consumed without any memory access, and `busy` stays low.
- R8: `busy` is high from the cycle after acceptance until the acknowledge of the final access. While it is high, `req_ready` is low and no request is taken.
- R9: While `mem_valid` is high and `mem_ack` is low, `mem_addr`, `mem_write`, `mem_wide` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Update request present |
| req_ready | output | 1 | Request taken when both valid and ready are high |
| req_id | input | ID_W | Interrupt identity (message data) |
| req_file_base | input | ADDR_W | Base address of the interrupt file |
| req_entry_w1 | input | 64 | Second word of the translation entry |
| busy | output | 1 | Update in progress |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 for write, 0 for read |
| mem_wide | output | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| mem_addr | output | ADDR_W | Access byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Access complete; read data valid in the same cycle |
| mem_rdata | input | 64 | Read data |

## Verification
The case that is hardest to reach from the ports is a second request arriving while an update is still in flight. The bench has to show that this request is neither accepted nor allowed to disturb the pending word. To get there, the memory responder stretches every access by a chosen latency. During the whole update the bench holds a competing request on the input and checks that `req_ready` stays low. The scoreboard's queue then shows that no access outside the expected sequence took place. Notice gating is reached by preloading the array so that the target bit is already pending, and also so that the enable word is zero.

// File: rtl/mrif_pkg.sv
package mrif_pkg;

   localparam int unsigned WORD_W      = 64;
   localparam int unsigned BIT_IDX_W   = $clog2(WORD_W);
   localparam int unsigned GRP_SHIFT   = 4;
   localparam int unsigned EN_OFFSET   = 8;
   localparam int unsigned NPAGE_LSB   = 10;
   localparam int unsigned NPAGE_MSB   = 53;
   localparam int unsigned NID_HI_BIT  = 60;
   localparam int unsigned NID_LO_W    = 10;
   localparam int unsigned PAGE_SHIFT  = 12;
   localparam int unsigned NOTE_ADDR_W = NPAGE_MSB - NPAGE_LSB + 1 + PAGE_SHIFT;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RD_PEND = 3'd1,
      ST_RD_EN   = 3'd2,
      ST_WR_PEND = 3'd3,
      ST_WR_NOTE = 3'd4
   } mrif_state_e;

endpackage

// File: rtl/mrif_addr_gen.sv
module mrif_addr_gen
   import mrif_pkg::*;
#(
   parameter int unsigned ADDR_W = 48,
   parameter int unsigned ID_W   = 32
) (
   input  logic [ADDR_W-1:0]    file_base,
   input  logic [ID_W-1:0]      ident,
   input  logic [WORD_W-1:0]    entry_w1,
   output logic [ADDR_W-1:0]    pend_addr,
   output logic [ADDR_W-1:0]    en_addr,
   output logic [ADDR_W-1:0]    note_addr,
   output logic [31:0]          note_id,
   output logic [BIT_IDX_W-1:0] bit_idx
);

   localparam int unsigned GRP_W = ID_W - BIT_IDX_W;
   localparam int unsigned OFF_W = GRP_W + GRP_SHIFT;

   logic [GRP_W-1:0]       group;
   logic [OFF_W-1:0]       grp_off;
   logic [NOTE_ADDR_W-1:0] note_full;

   assign group     = ident[ID_W-1:BIT_IDX_W];
   assign bit_idx   = ident[BIT_IDX_W-1:0];
   assign grp_off   = {group, {GRP_SHIFT{1'b0}}};
   assign pend_addr = file_base + ADDR_W'(grp_off);
   assign en_addr   = pend_addr + ADDR_W'(EN_OFFSET);
   assign note_full = {entry_w1[NPAGE_MSB:NPAGE_LSB], {PAGE_SHIFT{1'b0}}};
   assign note_id   = {21'd0, entry_w1[NID_HI_BIT], entry_w1[NID_LO_W-1:0]};

   generate
      if (ADDR_W >= NOTE_ADDR_W) begin : g_note_ext
         assign note_addr = {{(ADDR_W-NOTE_ADDR_W){1'b0}}, note_full};
      end else begin : g_note_trunc
         assign note_addr = note_full[ADDR_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/mrif_bit_merge.sv
module mrif_bit_merge
   import mrif_pkg::*;
(
   input  logic [WORD_W-1:0]    pend_word,
   input  logic [WORD_W-1:0]    en_word,
   input  logic [BIT_IDX_W-1:0] bit_idx,
   output logic [WORD_W-1:0]    pend_next,
   output logic                 need_note
);

   logic [WORD_W-1:0] sel_mask;

   assign sel_mask  = WORD_W'(1) << bit_idx;
   assign pend_next = pend_word | sel_mask;
   assign need_note = |(en_word & sel_mask & ~pend_word);

endmodule

// File: rtl/mrif_seq.sv
module mrif_seq
   import mrif_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        mem_ack,
   input  logic        need_note,
   output mrif_state_e state,
   output logic        busy
);

   mrif_state_e state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:    if (start)   state_nx = ST_RD_PEND;
         ST_RD_PEND: if (mem_ack) state_nx = ST_RD_EN;
         ST_RD_EN:   if (mem_ack) state_nx = ST_WR_PEND;
         ST_WR_PEND: if (mem_ack) state_nx = need_note ? ST_WR_NOTE : ST_IDLE;
         ST_WR_NOTE: if (mem_ack) state_nx = ST_IDLE;
         default:                 state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   assign busy = (state != ST_IDLE);

   // busy only ends on an acknowledged access
   assert_end_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(mem_ack));

   // a start while idle always leads into the pending read
   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state == ST_IDLE) |=> state == ST_RD_PEND);

endmodule

// File: rtl/mrif_notify_unit.sv
module mrif_notify_unit
   import mrif_pkg::*;
#(
   parameter int unsigned ADDR_W = 48,
   parameter int unsigned ID_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ID_W-1:0]   req_id,
   input  logic [ADDR_W-1:0] req_file_base,
   input  logic [63:0]       req_entry_w1,
   output logic              busy,
   output logic              mem_valid,
   output logic              mem_write,
   output logic              mem_wide,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [63:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [63:0]       mem_rdata
);

   generate
      if (ID_W <= BIT_IDX_W || ID_W > 32) begin : g_bad_id
         $error("ID_W must lie between BIT_IDX_W+1 and 32");
      end
      if (ADDR_W < PAGE_SHIFT + 1) begin : g_bad_addr
         $error("ADDR_W too small for a page-aligned notice address");
      end
   endgenerate

   mrif_state_e          state;
   logic                 accept, start, need_note;
   logic [ID_W-1:0]      id_q;
   logic [ADDR_W-1:0]    base_q;
   logic [WORD_W-1:0]    w1_q, pend_q, en_q, pend_next;
   logic [ADDR_W-1:0]    pend_addr, en_addr, note_addr;
   logic [31:0]          note_id;
   logic [BIT_IDX_W-1:0] bit_idx;

   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;
   assign start     = accept && (req_id != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q   <= '0;
         base_q <= '0;
         w1_q   <= '0;
      end else if (start) begin
         id_q   <= req_id;
         base_q <= req_file_base;
         w1_q   <= req_entry_w1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         en_q   <= '0;
      end else if (mem_ack) begin
         if (state == ST_RD_PEND) pend_q <= mem_rdata;
         if (state == ST_RD_EN)   en_q   <= mem_rdata;
      end
   end

   mrif_addr_gen #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_addr (
      .file_base (base_q),
      .ident     (id_q),
      .entry_w1  (w1_q),
      .pend_addr (pend_addr),
      .en_addr   (en_addr),
      .note_addr (note_addr),
      .note_id   (note_id),
      .bit_idx   (bit_idx)
   );

   mrif_bit_merge u_merge (
      .pend_word (pend_q),
      .en_word   (en_q),
      .bit_idx   (bit_idx),
      .pend_next (pend_next),
      .need_note (need_note)
   );

   mrif_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mem_ack   (mem_ack),
      .need_note (need_note),
      .state     (state),
      .busy      (busy)
   );

   always_comb begin
      mem_valid = busy;
      mem_write = 1'b0;
      mem_wide  = 1'b1;
      mem_addr  = pend_addr;
      mem_wdata = '0;
      unique case (state)
         ST_RD_EN:   mem_addr = en_addr;
         ST_WR_PEND: begin
            mem_write = 1'b1;
            mem_wdata = pend_next;
         end
         ST_WR_NOTE: begin
            mem_write = 1'b1;
            mem_wide  = 1'b0;
            mem_addr  = note_addr;
            mem_wdata = {32'd0, note_id};
         end
         default: ;
      endcase
   end

   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_valid);

   assert_en_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD_PEND && mem_ack) |=>
         (!mem_write && mem_addr == $past(mem_addr) + ADDR_W'(EN_OFFSET)));

   assert_pend_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write && mem_wide) |->
         (mem_wdata[bit_idx] && ((mem_wdata & pend_q) == pend_q)));

   assert_note_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write && !mem_wide) |-> (en_q[bit_idx] && !pend_q[bit_idx]));

   assert_zero_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_id == '0) |=> !busy);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)
                                   && $stable(mem_wide) && $stable(mem_wdata)));

endmodule

// File: tb/tb_mrif_notify_unit.sv
module tb_mrif_notify_unit;

   localparam int ADDR_W = 48;
   localparam int ID_W   = 32;

   typedef struct {
      bit          wr;
      bit          wide;
      logic [47:0] addr;
      logic [63:0] data;
      string       tag;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [ID_W-1:0]   req_id = '0;
   logic [ADDR_W-1:0] req_file_base = '0;
   logic [63:0]       req_entry_w1 = '0;
   logic              busy;
   logic              mem_valid, mem_write, mem_wide;
   logic [ADDR_W-1:0] mem_addr;
   logic [63:0]       mem_wdata;
   logic              mem_ack = 1'b0;
   logic [63:0]       mem_rdata = '0;

   int    checks = 0;
   int    errors = 0;
   int    lat = 0;
   item_t expq[$];
   logic [63:0] bmem [logic [47:0]];

   always #4 clk = ~clk;

   mrif_notify_unit #(.ADDR_W(ADDR_W), .ID_W(ID_W)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_id(req_id), .req_file_base(req_file_base), .req_entry_w1(req_entry_w1),
      .busy(busy), .mem_valid(mem_valid), .mem_write(mem_write), .mem_wide(mem_wide),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] rd(input logic [47:0] a);
      return bmem.exists(a) ? bmem[a] : 64'd0;
   endfunction

   // monitor: compares each completed access against the expected queue
   task automatic observe(input bit wr, input bit wide, input logic [47:0] a,
                          input logic [63:0] d);
      item_t e;
      if (expq.size() == 0) begin
         check(1'b0, "R6", "unexpected access addr", {16'd0, a}, 64'd0);
         return;
      end
      e = expq.pop_front();
      check(wr == e.wr && wide == e.wide, e.tag, "access kind", {62'd0, wr, wide},
            {62'd0, e.wr, e.wide});
      check(a == e.addr, e.tag, "address", {16'd0, a}, {16'd0, e.addr});
      if (e.wr) check(d == e.data, e.tag, "write data", d, e.data);
   endtask

   // memory responder with configurable latency; also checks request hold (R9)
   initial begin : responder
      int          wait_n = 0;
      logic [47:0] h_addr = '0;
      logic [63:0] h_data = '0;
      logic        h_wr = 1'b0;
      forever begin
         @(negedge clk);
         if (mem_ack) mem_ack = 1'b0;
         else if (rst_n && mem_valid) begin
            if (wait_n == 0) begin
               h_addr = mem_addr; h_data = mem_wdata; h_wr = mem_write;
            end else begin
               check(mem_addr == h_addr && mem_wdata == h_data && mem_write == h_wr,
                     "R9", "request held", {16'd0, mem_addr}, {16'd0, h_addr});
            end
            if (wait_n < lat) wait_n++;
            else begin
               wait_n = 0;
               observe(mem_write, mem_wide, mem_addr, mem_wdata);
               if (!mem_write) mem_rdata = rd(mem_addr);
               else if (mem_wide) bmem[mem_addr] = mem_wdata;
               mem_ack = 1'b1;
            end
         end
      end
   end

   // driver: pushes the expected access sequence, then issues the request
   task automatic send(input logic [31:0] id, input logic [47:0] base,
                       input logic [63:0] w1, input bit contend);
      logic [47:0] pa;
      logic [63:0] pw, ew, msk;
      logic [55:0] nfull;
      if (id != 0) begin
         pa = base + {14'd0, id[31:6], 4'd0};
         pw = rd(pa);
         ew = rd(pa + 48'd8);
         msk = 64'd1 << id[5:0];
         nfull = {w1[53:10], 12'd0};
         expq.push_back('{1'b0, 1'b1, pa, 64'd0, "R2"});
         expq.push_back('{1'b0, 1'b1, pa + 48'd8, 64'd0, "R2"});
         expq.push_back('{1'b1, 1'b1, pa, pw | msk, "R3"});
         if ((ew & msk) != 0 && (pw & msk) == 0)
            expq.push_back('{1'b1, 1'b0, nfull[47:0],
                             {53'd0, w1[60], w1[9:0]}, "R5"});
      end
      @(negedge clk);
      check(req_ready == 1'b1, "R8", "ready before request", {63'd0, req_ready}, 64'd1);
      req_valid = 1'b1; req_id = id; req_file_base = base; req_entry_w1 = w1;
      @(negedge clk);
      req_valid = 1'b0;
      if (id == 0) begin
         check(busy == 1'b0 && mem_valid == 1'b0, "R7", "zero identity idle",
               {62'd0, busy, mem_valid}, 64'd0);
         repeat (3) @(negedge clk);
         check(mem_valid == 1'b0, "R7", "no access for zero", {63'd0, mem_valid}, 64'd0);
      end else begin
         check(busy == 1'b1, "R8", "busy after accept", {63'd0, busy}, 64'd1);
         while (busy) begin
            if (contend) begin
               req_valid = 1'b1; req_id = 32'd5;
               check(req_ready == 1'b0, "R8", "ready low while busy",
                     {63'd0, req_ready}, 64'd0);
            end
            @(negedge clk);
         end
         req_valid = 1'b0;
      end
      check(expq.size() == 0, "R6", "pending expected accesses",
            64'(expq.size()), 64'd0);
      expq.delete();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [63:0] w1a, w1b, w1c;
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && mem_valid == 1'b0 && req_ready == 1'b1, "R1", "reset state",
            {61'd0, busy, mem_valid, req_ready}, 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && mem_valid == 1'b0, "R1", "idle after reset",
            {62'd0, busy, mem_valid}, 64'd0);

      w1a = (64'h8_0000 >> 2) | (64'd1 << 60) | 64'd5;     // notice id 1029
      w1b = (64'h9_0000 >> 2) | (64'd1 << 60) | 64'd90;    // notice id 1114
      w1c = (64'hA_B000 >> 2) | 64'h3ff;                   // notice id 1023
      bmem[48'h1008] = '1;
      bmem[48'h2010] = 64'd3;
      bmem[48'h2018] = '1;
      bmem[48'h3028] = 64'd0;
      bmem[48'h4408] = 64'h8;

      lat = 0; send(32'd4, 48'h1000, w1a, 1'b0);           // R4 R5 notice posted
      check(rd(48'h1000) == 64'h10, "R3", "bit 4 set", rd(48'h1000), 64'h10);
      lat = 2; send(32'd70, 48'h2000, w1b, 1'b1);          // R3 preserves bits 0,1
      check(rd(48'h2010) == 64'h43, "R3", "bit 6 merged", rd(48'h2010), 64'h43);
      lat = 1; send(32'd70, 48'h2000, w1b, 1'b1);          // R6 already pending: no notice
      lat = 3; send(32'd130, 48'h3000, w1a, 1'b0);         // R6 disabled: no notice
      check(rd(48'h3020) == 64'h4, "R3", "bit 2 set", rd(48'h3020), 64'h4);
      lat = 0; send(32'd0, 48'h1000, w1a, 1'b0);           // R7 ignored
      lat = 2; send(32'h1003, 48'h4000, w1c, 1'b1);        // R2 far group, R4 R5
      lat = 1; send(32'd63, 48'h1000, w1c, 1'b0);          // top bit of group
      check(rd(48'h1000) == 64'h8000_0000_0000_0010, "R3", "bit 63 merged",
            rd(48'h1000), 64'h8000_0000_0000_0010);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule